// File: doc/BRIEF.md
# CPU Wait and Stop Controller

This unit sits beside the instruction sequencer of an 8-bit processor core and handles the two low-power pause instructions. It watches the opcode that the core presents with an execute strobe. When it sees the wait-for-interrupt or the stop opcode, it runs a single dummy-read cycle and then raises a pause flag. While any pause is active, it holds the core's step enable low.

The two pauses wake up under different rules. An interrupt request or a non-maskable interrupt ends a wait. Only reset ends a stop. The unit also gives the core a one-cycle strobe that clears the decimal-mode status bit. The strobe fires whenever an interrupt sequence starts: reset, a new interrupt request, a new non-maskable interrupt, or a software break.

All control lines are active low and are sampled synchronously on the rising clock edge. Step enable is a registered output, so the core sees each pause change one cycle after the edge that caused it.

Top module: `cpu_pause_ctrl`

## Requirements
- R1: While `rstN` is sampled low, the next cycle shows `waiting`, `stopped`, `dummyRd` and `stepEn` all low and `decClr` high. The first edge that samples `rstN` high raises `stepEn`. A reset sampled during a dummy-read cycle cancels the pending pause.
- R2: An execute strobe accepted while `stepEn` is high, with opcode 0xCB (wait), gives one cycle with `dummyRd` high and `stepEn` low. On the following edge `waiting` goes high and `stepEn` stays low.
- R3: An accepted strobe with opcode 0xDB (stop) gives one dummy-read cycle in the same way. On the following edge `stopped` goes high and `stepEn` stays low.
- R4: While `waiting`, `stopped` or `dummyRd` is high, `stepEn` is low and execute strobes are ignored, whatever their opcode.
- R5: `irqN` or `nmiN` sampled low while waiting clears `waiting` and raises `stepEn` on that same edge. If either line is low at the edge that ends a wait's dummy cycle, `waiting` never rises.
- R6: `irqN` and `nmiN` have no effect on `stopped`. Only reset clears it.
- R7: `decClr` is high for exactly one cycle after any of these edges: an edge that sees `irqN` go from high to low, an edge that sees `nmiN` go from high to low, or an edge that accepts opcode 0x00 (break). `stepEn` is not affected by these events.
- R8: When reset and an accepted wait opcode arrive at the same edge, reset wins. Neither flag is set and no dummy cycle follows.
- R9: Any accepted opcode other than 0xCB, 0xDB and 0x00 leaves every output at its running value (`stepEn` high, all others low).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| irqN | input | 1 | Maskable interrupt request, active low |
| nmiN | input | 1 | Non-maskable interrupt, active low |
| execStb | input | 1 | Opcode valid for execution this cycle |
| opcode | input | 8 | Opcode byte presented by the core |
| stepEn | output | 1 | Core may advance its instruction steps |
| dummyRd | output | 1 | Dummy-read cycle of a pause instruction |
| decClr | output | 1 | One-cycle strobe that clears the decimal flag |
| waiting | output | 1 | Wait-for-interrupt pause active |
| stopped | output | 1 | Stop pause active |

## Verification
The hardest case to reach from the ports is an interrupt line that is already low when a wait's dummy cycle ends. The request and the flag set then collide on one edge, and the wake has to win. The stimulus gets there in two steps. It first drops `irqN` and lets the resulting decimal-clear pulse pass. It then issues the wait opcode, so the low level is still present at the edge that would set `waiting`. A second hard case is a reset arriving in the middle of a dummy-read cycle. The stimulus reaches it by asserting `rstN` on the cycle right after a stop opcode is accepted.

// File: rtl/pause_pkg.sv
package pause_pkg;

  typedef enum logic [1:0] {
    PH_RUN        = 2'd0,
    PH_DUMMY_WAIT = 2'd1,
    PH_DUMMY_STOP = 2'd2
  } pause_phase_e;

  // Strobes sent from the control unit to the flag datapath
  typedef struct packed {
    logic setWait;    // wait dummy cycle is finishing
    logic setStop;    // stop dummy cycle is finishing
    logic wake;       // some interrupt line is low this cycle
    logic decEvt;     // an interrupt sequence is being entered
    logic dummyNext;  // a dummy cycle follows this edge
  } pause_cmd_t;

endpackage

// File: rtl/pause_ctrl.sv
module pause_ctrl
  import pause_pkg::*;
#(
  parameter int          OPW     = 8,
  parameter int          NUM_INT = 2,
  parameter logic [OPW-1:0] OP_WAIT = 8'hCB,
  parameter logic [OPW-1:0] OP_STOP = 8'hDB,
  parameter logic [OPW-1:0] OP_BRK  = 8'h00
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_INT-1:0] intN,
  input  logic               execStb,
  input  logic [OPW-1:0]     opcode,
  input  logic               stepEn,
  output pause_cmd_t         cmd,
  output logic               dummyRd
);

  pause_phase_e phase, phaseNext;
  logic         accept;
  logic [NUM_INT-1:0] intPrev;
  logic [NUM_INT-1:0] intFell;

  assign accept = stepEn && execStb;

  // Phase sequencing: a pause opcode always costs one dummy-read cycle
  always_comb begin
    phaseNext = phase;
    if (!rstN) begin
      phaseNext = PH_RUN;
    end else begin
      case (phase)
        PH_RUN: begin
          if (accept && opcode == OP_WAIT)      phaseNext = PH_DUMMY_WAIT;
          else if (accept && opcode == OP_STOP) phaseNext = PH_DUMMY_STOP;
        end
        PH_DUMMY_WAIT, PH_DUMMY_STOP: phaseNext = PH_RUN;
        default: phaseNext = PH_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    phase <= phaseNext;
  end

  assign dummyRd = (phase != PH_RUN);

  // Falling-edge detectors, one per interrupt line
  for (genvar g = 0; g < NUM_INT; g++) begin : gEdge
    always_ff @(posedge clk) begin
      if (!rstN) intPrev[g] <= 1'b1;
      else       intPrev[g] <= intN[g];
    end
    assign intFell[g] = intPrev[g] && !intN[g];
  end

  always_comb begin
    cmd.setWait   = (phase == PH_DUMMY_WAIT);
    cmd.setStop   = (phase == PH_DUMMY_STOP);
    cmd.wake      = !(&intN);
    cmd.decEvt    = (|intFell) || (accept && opcode == OP_BRK);
    cmd.dummyNext = (phaseNext != PH_RUN);
  end

  // R2/R3: an accepted pause opcode yields a dummy-read cycle next
  a_r2_dummy_follows: assert property (@(posedge clk) disable iff (!rstN)
    (accept && (opcode == OP_WAIT || opcode == OP_STOP)) |=> dummyRd);

  // R2: dummy-read lasts exactly one cycle
  a_r2_dummy_single: assert property (@(posedge clk) disable iff (!rstN)
    dummyRd |=> !dummyRd);

  // R4: strobes are never accepted during a dummy cycle
  a_r4_no_accept_dummy: assert property (@(posedge clk) disable iff (!rstN)
    dummyRd |-> !accept);

endmodule

// File: rtl/pause_dp.sv
module pause_dp
  import pause_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  pause_cmd_t cmd,
  output logic       stepEn,
  output logic       decClr,
  output logic       waiting,
  output logic       stopped
);

  logic waitNext;
  logic stopNext;

  // Wake beats a wait that is just being set; reset beats everything
  always_comb begin
    if (!rstN)            waitNext = 1'b0;
    else if (cmd.wake)    waitNext = 1'b0;
    else if (cmd.setWait) waitNext = 1'b1;
    else                  waitNext = waiting;
  end

  always_comb begin
    if (!rstN)            stopNext = 1'b0;
    else if (cmd.setStop) stopNext = 1'b1;
    else                  stopNext = stopped;
  end

  always_ff @(posedge clk) begin
    waiting <= waitNext;
    stopped <= stopNext;
    stepEn  <= rstN && !(waitNext || stopNext || cmd.dummyNext);
    decClr  <= !rstN || cmd.decEvt;
  end

  // R4: no stepping while a pause flag is set
  a_r4_paused_blocks_step: assert property (@(posedge clk) disable iff (!rstN)
    (waiting || stopped) |-> !stepEn);

  // R6: stop persists until reset
  a_r6_stop_holds: assert property (@(posedge clk) disable iff (!rstN)
    stopped |=> stopped);

  // R5: a low interrupt line ends a wait on the next edge
  a_r5_wake_clears: assert property (@(posedge clk) disable iff (!rstN)
    (waiting && cmd.wake) |=> (!waiting && stepEn));

  // R2: the end of a wait dummy cycle sets the flag unless woken
  a_r2_wait_sets: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.setWait && !cmd.wake) |=> waiting);

  // R3: the end of a stop dummy cycle sets the flag
  a_r3_stop_sets: assert property (@(posedge clk) disable iff (!rstN)
    cmd.setStop |=> stopped);

endmodule

// File: rtl/cpu_pause_ctrl.sv
module cpu_pause_ctrl
  import pause_pkg::*;
#(
  parameter int OPW = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           irqN,
  input  logic           nmiN,
  input  logic           execStb,
  input  logic [OPW-1:0] opcode,
  output logic           stepEn,
  output logic           dummyRd,
  output logic           decClr,
  output logic           waiting,
  output logic           stopped
);

  localparam int NUM_INT = 2;

  pause_cmd_t         cmd;
  logic [NUM_INT-1:0] intN;

  assign intN = {nmiN, irqN};

  pause_ctrl #(
    .OPW     (OPW),
    .NUM_INT (NUM_INT)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .intN    (intN),
    .execStb (execStb),
    .opcode  (opcode),
    .stepEn  (stepEn),
    .cmd     (cmd),
    .dummyRd (dummyRd)
  );

  pause_dp uDp (
    .clk     (clk),
    .rstN    (rstN),
    .cmd     (cmd),
    .stepEn  (stepEn),
    .decClr  (decClr),
    .waiting (waiting),
    .stopped (stopped)
  );

  // R7: a new non-maskable interrupt strobes the decimal clear
  a_r7_nmi_decclr: assert property (@(posedge clk) disable iff (!rstN)
    $fell(nmiN) |=> decClr);

  // R7: a new interrupt request strobes the decimal clear
  a_r7_irq_decclr: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqN) |=> decClr);

endmodule

// File: tb/sim_cpu_pause_ctrl.sv
`timescale 1ns/1ps
module sim_cpu_pause_ctrl;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       irqN = 1'b1;
  logic       nmiN = 1'b1;
  logic       execStb = 1'b0;
  logic [7:0] opcode = 8'hEA;
  logic       stepEn, dummyRd, decClr, waiting, stopped;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  cpu_pause_ctrl u0 (
    .clk(clk), .rstN(rstN), .irqN(irqN), .nmiN(nmiN),
    .execStb(execStb), .opcode(opcode),
    .stepEn(stepEn), .dummyRd(dummyRd), .decClr(decClr),
    .waiting(waiting), .stopped(stopped)
  );

  // Expected vector order: {stepEn, dummyRd, decClr, waiting, stopped}
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [4:0] exp);
    logic [4:0] act;
    act = {stepEn, dummyRd, decClr, waiting, stopped};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: {step,dummy,dec,wait,stop} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic idle();
    execStb = 1'b0;
    opcode  = 8'hEA;
  endtask

  task automatic issue(logic [7:0] op);
    execStb = 1'b1;
    opcode  = op;
  endtask

  task automatic t_reset();
    rstN = 1'b0; idle();
    tick(); chk("R1 in reset", 5'b00100);
    tick(); chk("R1 held reset", 5'b00100);
    rstN = 1'b1;
    tick(); chk("R1 release", 5'b10000);
  endtask

  task automatic t_wait_irq();
    issue(8'hCB);
    tick(); chk("R2 dummy cycle", 5'b01000);
    idle();
    tick(); chk("R2 waiting set", 5'b00010);
    tick(); chk("R2 waiting holds", 5'b00010);
    issue(8'hDB);
    tick(); chk("R4 stop ignored while waiting", 5'b00010);
    idle(); irqN = 1'b0;
    tick(); chk("R5 irq wakes", 5'b10100);
    tick(); chk("R7 pulse ends", 5'b10000);
    irqN = 1'b1;
    tick(); chk("R5 running", 5'b10000);
  endtask

  task automatic t_wait_nmi();
    issue(8'hCB);
    tick(); chk("R2 dummy", 5'b01000);
    issue(8'hDB);
    tick(); chk("R4 strobe in dummy ignored", 5'b00010);
    idle(); nmiN = 1'b0;
    tick(); chk("R5 nmi wakes", 5'b10100);
    nmiN = 1'b1;
    tick(); chk("R5 stays running", 5'b10000);
  endtask

  task automatic t_wait_irq_early();
    irqN = 1'b0;
    tick(); chk("R7 irq fall", 5'b10100);
    issue(8'hCB);
    tick(); chk("R2 dummy with irq low", 5'b01000);
    idle();
    tick(); chk("R5 wait never set", 5'b10000);
    irqN = 1'b1;
    tick(); chk("R5 running", 5'b10000);
  endtask

  task automatic t_stop();
    issue(8'hDB);
    tick(); chk("R3 dummy", 5'b01000);
    idle();
    tick(); chk("R3 stopped set", 5'b00001);
    irqN = 1'b0;
    tick(); chk("R6 irq ignored", 5'b00101);
    nmiN = 1'b0;
    tick(); chk("R6 nmi ignored", 5'b00101);
    tick(); chk("R6 still stopped", 5'b00001);
    irqN = 1'b1; nmiN = 1'b1;
    issue(8'hCB);
    tick(); chk("R4 wait ignored while stopped", 5'b00001);
    idle(); rstN = 1'b0;
    tick(); chk("R1 reset clears stop", 5'b00100);
    rstN = 1'b1;
    tick(); chk("R1 running after stop", 5'b10000);
  endtask

  task automatic t_brk_and_other();
    issue(8'h00);
    tick(); chk("R7 brk pulse", 5'b10100);
    idle();
    tick(); chk("R7 brk pulse one cycle", 5'b10000);
    issue(8'hEA);
    tick(); chk("R9 nop", 5'b10000);
    issue(8'hCA);
    tick(); chk("R9 near wait", 5'b10000);
    issue(8'hDA);
    tick(); chk("R9 near stop", 5'b10000);
    issue(8'h4B);
    tick(); chk("R9 other", 5'b10000);
    idle();
  endtask

  task automatic t_reset_collide();
    rstN = 1'b0; issue(8'hCB);
    tick(); chk("R8 reset with wait", 5'b00100);
    rstN = 1'b1; idle();
    tick(); chk("R8 no dummy", 5'b10000);
    tick(); chk("R8 no wait", 5'b10000);
  endtask

  task automatic t_reset_in_dummy();
    issue(8'hDB);
    tick(); chk("R3 dummy", 5'b01000);
    idle(); rstN = 1'b0;
    tick(); chk("R1 reset in dummy", 5'b00100);
    rstN = 1'b1;
    tick(); chk("R1 pause cancelled", 5'b10000);
    tick(); chk("R1 no late stop", 5'b10000);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_wait_irq();
    t_wait_nmi();
    t_wait_irq_early();
    t_stop();
    t_brk_and_other();
    t_reset_collide();
    t_reset_in_dummy();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule